// File: doc/BRIEF.md
# Serial Bit I/O Bus Cycle Sequencer

This block is the processor-side master for a serial bus on which every transfer moves one addressed bit. A host asks for a transfer by giving a bit address, a direction and, for a write, a single data bit. The sequencer then runs one fixed transaction on the bus. It drives the bit address, drives the data-out line and pulses a low-true write strobe for writes, or samples the data-in line for reads. At the end it reports completion with a one-tick pulse.

A free-running phase counter splits every bus clock cycle into four phase ticks, and all bus events fall on tick boundaries. A transaction always starts on phase 1 of a bus cycle and lasts exactly two bus cycles, which is eight ticks. The address is held from the first tick to the last, so it has four full ticks to settle before the commit point. That commit point is phase 1 of the second cycle. A write strobe is low for exactly that phase and rises on its trailing edge, and that rising edge is where the peripheral latches the data. A read samples data-in on the leading edge of the same phase.

Top module: `bitbus_seq`

## Requirements
- R1: After reset, busy, done, bus_dout and rdata are 0, bus_addr is 0 and bus_wstb_n is 1.
- R2: A request (req high while busy is low) is taken on the last phase tick of a bus cycle. busy rises on the following tick, which is phase 1 of a new bus cycle, so a held request waits at most four ticks.
- R3: busy stays high for exactly eight phase ticks (two bus cycles) for both reads and writes.
- R4: bus_addr shows the request address from the first tick of the transaction to the last, does not change within it, and is 0 whenever busy is low.
- R5: During a write (rw = 0), bus_dout carries the request's data bit for the whole transaction. During reads and while idle it is 0.
- R6: On a write, bus_wstb_n is low for exactly one tick, the fifth tick of the transaction (phase 1 of bus cycle 2), and high at all other times. On a read it stays high throughout.
- R7: On a read (rw = 1), bus_din is sampled once, at the clock edge that opens the fifth tick. Values before or after that edge have no effect on the result.
- R8: done is high for exactly one tick, the tick in which busy has just fallen. For a read, rdata shows the sampled bit from that tick on.
- R9: rdata keeps its value until the next read completes. Write transactions leave it unchanged.
- R10: Changes on req, rw, addr and wdata while busy is high are ignored. The running transaction's address, data, strobe and result are unaffected, and no new transaction starts from them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase tick clock (one edge per phase tick) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Transfer request, held until busy rises |
| rw | input | 1 | Direction: 1 = read, 0 = write |
| addr | input | 12 | Bit address for the transfer |
| wdata | input | 1 | Bit to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-tick completion pulse |
| rdata | output | 1 | Last bit read |
| bus_addr | output | 12 | Bit address bus |
| bus_dout | output | 1 | Serial data-out line |
| bus_wstb_n | output | 1 | Low-true write strobe |
| bus_din | input | 1 | Serial data-in line from the peripheral |

## Verification
The properties assume that the host holds req until busy rises and changes the request fields only between transfers or while busy is high. They also assume that the peripheral sets up bus_din before the sampling edge. The bench drives every request at a falling clock edge and drops req as soon as busy is seen. Its peripheral model drives data-in from a bit array indexed by the address bus and latches on the strobe's rising edge. In one read mode the model drives a wrong bit until the second tick and again from the fifth tick. The correct bit is therefore on the line for the two full ticks before the sample edge and for no other window, which shows that only the sample edge counts.

// File: rtl/bitbus_pkg.sv
package bitbus_pkg;
    // A transaction spans this many bus clock cycles; fixed by the bus protocol.
    localparam int XFER_CYCLES = 2;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } xfer_st_e;
endpackage

// File: rtl/bitbus_phase.sv
// Free-running phase counter: one count per phase tick, wrapping each bus cycle.
module bitbus_phase #(
    parameter int PHASES = 4,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            last_phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        if (ph_q.ph == PH_LAST) ph_d.ph = '0;
        else                    ph_d.ph = ph_q.ph + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

    assign phase      = ph_q.ph;
    assign last_phase = (ph_q.ph == PH_LAST);
endmodule

// File: rtl/bitbus_ctrl.sv
// Transaction controller: accepts a request on a cycle boundary, counts slots.
module bitbus_ctrl
    import bitbus_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PHASES = 4,
    localparam int SLOTS  = PHASES * XFER_CYCLES,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wdata,
    input  logic              last_phase,
    output logic              busy,
    output logic              run_nx,
    output logic              rd_nx,
    output logic [ADDR_W-1:0] addr_nx,
    output logic              wbit_nx,
    output logic [SLOT_W-1:0] slot_nx,
    output logic              rd_now,
    output logic              sample_now,
    output logic              finish_now
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] SLOT_SMP  = SLOT_W'(SLOTS - PHASES - 1);

    typedef struct packed {
        xfer_st_e          st;
        logic [SLOT_W-1:0] slot;
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic              wbit;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  accept;

    always_comb begin
        c_d    = c_q;
        accept = (c_q.st == ST_IDLE) && req && last_phase;
        if (accept) begin
            c_d.st   = ST_XFER;
            c_d.slot = '0;
            c_d.rd   = rw;
            c_d.addr = addr;
            c_d.wbit = rw ? 1'b0 : wdata;
        end else if (c_q.st == ST_XFER) begin
            if (c_q.slot == SLOT_LAST) begin
                c_d.st   = ST_IDLE;
                c_d.slot = '0;
                c_d.addr = '0;
                c_d.wbit = 1'b0;
            end else begin
                c_d.slot = c_q.slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.st   <= ST_IDLE;
            c_q.slot <= '0;
            c_q.rd   <= 1'b0;
            c_q.addr <= '0;
            c_q.wbit <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy       = (c_q.st == ST_XFER);
    assign run_nx     = (c_d.st == ST_XFER);
    assign rd_nx      = c_d.rd;
    assign addr_nx    = c_d.addr;
    assign wbit_nx    = c_d.wbit;
    assign slot_nx    = c_d.slot;
    assign rd_now     = c_q.rd;
    assign sample_now = busy && (c_q.slot == SLOT_SMP);
    assign finish_now = busy && (c_q.slot == SLOT_LAST);
endmodule

// File: rtl/bitbus_pins.sv
// Registered bus pin stage: address, data-out, strobe, input sample, result.
module bitbus_pins
    import bitbus_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PHASES = 4,
    localparam int SLOTS  = PHASES * XFER_CYCLES,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_nx,
    input  logic              rd_nx,
    input  logic [ADDR_W-1:0] addr_nx,
    input  logic              wbit_nx,
    input  logic [SLOT_W-1:0] slot_nx,
    input  logic              rd_now,
    input  logic              sample_now,
    input  logic              finish_now,
    input  logic              bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_dout,
    output logic              bus_wstb_n,
    output logic              done,
    output logic              rdata
);
    // Commit slot: first phase of the final bus cycle.
    localparam logic [SLOT_W-1:0] SLOT_STB = SLOT_W'(SLOTS - PHASES);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              dout;
        logic              wstb_n;
        logic              samp;
        logic              done;
        logic              rdata;
    } pins_t;

    pins_t p_d, p_q;

    always_comb begin
        p_d        = p_q;
        p_d.addr   = run_nx ? addr_nx : '0;
        p_d.dout   = run_nx && !rd_nx && wbit_nx;
        p_d.wstb_n = !(run_nx && !rd_nx && (slot_nx == SLOT_STB));
        if (sample_now) p_d.samp = bus_din;
        p_d.done   = finish_now;
        if (finish_now && rd_now) p_d.rdata = p_q.samp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.addr   <= '0;
            p_q.dout   <= 1'b0;
            p_q.wstb_n <= 1'b1;
            p_q.samp   <= 1'b0;
            p_q.done   <= 1'b0;
            p_q.rdata  <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign bus_addr   = p_q.addr;
    assign bus_dout   = p_q.dout;
    assign bus_wstb_n = p_q.wstb_n;
    assign done       = p_q.done;
    assign rdata      = p_q.rdata;
endmodule

// File: rtl/bitbus_seq.sv
// Top: serial bit I/O bus cycle sequencer.
module bitbus_seq
    import bitbus_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int PHASES = 4,
    localparam int PH_W   = $clog2(PHASES),
    localparam int SLOT_W = $clog2(PHASES * XFER_CYCLES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wdata,
    output logic              busy,
    output logic              done,
    output logic              rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_dout,
    output logic              bus_wstb_n,
    input  logic              bus_din
);
    logic [PH_W-1:0]   phase;
    logic              last_phase;
    logic              run_nx, rd_nx, wbit_nx, rd_now, sample_now, finish_now;
    logic [ADDR_W-1:0] addr_nx;
    logic [SLOT_W-1:0] slot_nx;

    bitbus_phase #(.PHASES(PHASES)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .last_phase (last_phase)
    );

    bitbus_ctrl #(.ADDR_W(ADDR_W), .PHASES(PHASES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .rw         (rw),
        .addr       (addr),
        .wdata      (wdata),
        .last_phase (last_phase),
        .busy       (busy),
        .run_nx     (run_nx),
        .rd_nx      (rd_nx),
        .addr_nx    (addr_nx),
        .wbit_nx    (wbit_nx),
        .slot_nx    (slot_nx),
        .rd_now     (rd_now),
        .sample_now (sample_now),
        .finish_now (finish_now)
    );

    bitbus_pins #(.ADDR_W(ADDR_W), .PHASES(PHASES)) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_nx     (run_nx),
        .rd_nx      (rd_nx),
        .addr_nx    (addr_nx),
        .wbit_nx    (wbit_nx),
        .slot_nx    (slot_nx),
        .rd_now     (rd_now),
        .sample_now (sample_now),
        .finish_now (finish_now),
        .bus_din    (bus_din),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .bus_wstb_n (bus_wstb_n),
        .done       (done),
        .rdata      (rdata)
    );
endmodule

// File: rtl/bitbus_seq_chk.sv
// Protocol checker bound into the sequencer top.
module bitbus_seq_chk #(
    parameter int ADDR_W = 12,
    parameter int PH_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_dout,
    input logic              bus_wstb_n,
    input logic [PH_W-1:0]   phase
);
    // R2
    busy_start_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (phase == '0));

    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(bus_addr));

    // R4
    idle_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_addr == '0));

    // R5
    idle_dout_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_dout);

    // R5
    strobe_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wstb_n |-> $stable(bus_dout));

    // R6
    strobe_single_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_wstb_n) |=> bus_wstb_n);

    // R6
    strobe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wstb_n |-> (busy && (phase == '0)));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
endmodule

bind bitbus_seq bitbus_seq_chk #(.ADDR_W(ADDR_W), .PH_W(PH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .done       (done),
    .bus_addr   (bus_addr),
    .bus_dout   (bus_dout),
    .bus_wstb_n (bus_wstb_n),
    .phase      (phase)
);

// File: tb/tb_bitbus_seq.sv
`timescale 1ns/1ps
module tb_bitbus_seq;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, rw = 1'b0, wdata = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          busy, done, rdata, bus_dout, bus_wstb_n, bus_din;
    logic [AW-1:0] bus_addr;

    bit pmem   [0:(1<<AW)-1];
    bit shadow [0:(1<<AW)-1];
    bit din_xor = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    typedef struct {
        bit          rd;
        logic [AW-1:0] a;
        bit          val;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;

    bitbus_seq dut (
        .clk(clk), .rst_n(rst_n), .req(req), .rw(rw), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .rdata(rdata), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_wstb_n(bus_wstb_n), .bus_din(bus_din)
    );

    // Peripheral model: bit register array latched on strobe rising edge.
    assign bus_din = pmem[bus_addr] ^ din_xor;
    always @(posedge bus_wstb_n) if (rst_n) pmem[bus_addr] <= bus_dout;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Driver: pushes the expected item, runs the handshake, checks pins per tick.
    task automatic xfer(input bit rd, input logic [AW-1:0] a, input bit wb,
                        input bit jitter, input bit intrude);
        item_t it;
        int waited;
        int tick;
        it.rd = rd; it.a = a; it.val = rd ? shadow[a] : wb;
        if (!rd) shadow[a] = wb;
        sb.push_back(it);
        @(negedge clk);
        req = 1'b1; rw = rd; addr = a; wdata = wb;
        if (jitter) din_xor = 1'b1;
        waited = 0;
        while (!busy) begin @(negedge clk); waited++; end
        chk(waited >= 1 && waited <= 4, "R2 wait ticks", waited, 4);
        req = 1'b0; rw = ~rd; addr = ~a; wdata = ~wb;
        if (intrude) begin req = 1'b1; addr = a ^ 12'hABC; end
        tick = 1;
        while (busy) begin
            chk(bus_addr == a, "R4 bus_addr", int'(bus_addr), int'(a));
            chk(bus_dout == (rd ? 1'b0 : wb), "R5 bus_dout", int'(bus_dout), int'(rd ? 1'b0 : wb));
            if (jitter && tick == 2) din_xor = 1'b0;
            if (jitter && tick == 5) din_xor = 1'b1;
            @(negedge clk);
            tick++;
        end
        chk(tick == 9, "R3 busy ticks", tick - 1, 8);
        chk(done == 1'b1, "R8 done with busy low", int'(done), 1);
        din_xor = 1'b0;
        if (intrude) begin
            req = 1'b0;
            repeat (8) begin
                @(negedge clk);
                chk(!busy && bus_addr == '0, "R10 no restart", int'(busy), 0);
            end
        end
    endtask

    // Monitor: counts strobe ticks and pops the scoreboard on done.
    int  tcount = 0, scount = 0, spos = 0;
    bit  prev_done = 1'b0;
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            if (busy) begin
                tcount++;
                if (!bus_wstb_n) begin scount++; spos = tcount; end
            end else if (!bus_wstb_n) begin
                chk(1'b0, "R6 strobe while idle", 0, 1);
            end
            if (done && prev_done) chk(1'b0, "R8 done longer than one tick", 2, 1);
            if (done) begin
                item_t it;
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    it = sb.pop_front();
                    if (it.rd) begin
                        chk(scount == 0, "R6 no strobe on read", scount, 0);
                        chk(rdata == it.val, "R7 rdata", int'(rdata), int'(it.val));
                    end else begin
                        chk(scount == 1 && spos == 5, "R6 strobe count/position",
                            scount * 10 + spos, 15);
                        chk(pmem[it.a] == it.val, "R5 latched bit", int'(pmem[it.a]), int'(it.val));
                    end
                end
                tcount = 0; scount = 0; spos = 0;
            end
            prev_done = done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] alist [6];
        bit            blist [6];
        alist = '{12'h000, 12'h001, 12'h5A5, 12'hFFF, 12'h800, 12'h123};
        blist = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(busy == 0 && done == 0 && bus_dout == 0 && rdata == 0, "R1 outputs low",
            int'({busy, done, bus_dout, rdata}), 0);
        chk(bus_addr == '0 && bus_wstb_n == 1'b1, "R1 bus idle", int'(bus_wstb_n), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && bus_addr == '0, "R1 idle after reset", int'(busy), 0);

        for (int i = 0; i < 6; i++) xfer(1'b0, alist[i], blist[i], 1'b0, 1'b0);
        for (int i = 0; i < 6; i++) xfer(1'b1, alist[i], 1'b0, 1'b0, 1'b0);
        // Overwrite and read back; unwritten address reads 0.
        xfer(1'b0, 12'h5A5, 1'b0, 1'b0, 1'b0);
        xfer(1'b1, 12'h5A5, 1'b0, 1'b0, 1'b0);
        xfer(1'b1, 12'h777, 1'b0, 1'b0, 1'b0);
        // R7 sample point: wrong bit on the line outside the sample window.
        xfer(1'b1, 12'hFFF, 1'b0, 1'b1, 1'b0);
        xfer(1'b1, 12'h001, 1'b0, 1'b1, 1'b0);
        // R9 rdata held across a write.
        xfer(1'b1, 12'h000, 1'b0, 1'b0, 1'b0);
        xfer(1'b0, 12'h321, 1'b0, 1'b0, 1'b0);
        chk(rdata == 1'b1, "R9 rdata held after write", int'(rdata), 1);
        repeat (5) @(negedge clk);
        chk(rdata == 1'b1, "R9 rdata held while idle", int'(rdata), 1);
        // R10 request fields changed while busy.
        xfer(1'b0, 12'h0F0, 1'b1, 1'b0, 1'b1);
        xfer(1'b1, 12'h0F0, 1'b0, 1'b0, 1'b1);
        chk(pmem[12'h0F0 ^ 12'hABC] == 1'b0, "R10 intruding write absent",
            int'(pmem[12'h0F0 ^ 12'hABC]), 0);
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R8 all transfers completed", sb.size(), 0);
        ended = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule